// File: doc/BRIEF.md
# Jump-Synchronised Paged Memory Mapper

This block sits on an 8-bit address bus. For every bus address it selects one of four regions: a 128-byte paged ROM window, a 64-byte paged RAM window, 56 bytes of unpaged static RAM, or an eight-address register window. It adds page bits from two page registers to the window offset, so the ROM and RAM devices behind the bus receive a wider address.

Software writes a new page number to one of two register addresses. The value is held as pending and does not move the active page yet. The pending values are copied to the active page outputs only on the clock in which the program counter takes a jump. That jump is a write to the unconditional-jump address, or a write to the conditional-jump address while carry is set. Code running in one page can therefore prepare a transfer into another page. Its own instruction stream is not switched away underneath it.

Region selects, extended addresses and static RAM strobes are combinational from the bus. The only state is the pending and active page values.

Top module: `pgmap_top`

## Requirements
- R1: An address with bit 7 clear (0x00–0x7F) asserts `rom_sel`. `rom_xaddr` equals {active ROM page, addr[6:0]}.
- R2: An address in 0x80–0xBF asserts `ram_sel`. `ram_xaddr` equals {active RAM page, addr[5:0]}.
- R3: An address in 0xC0–0xF7 asserts `sram_sel`. `sram_xaddr` equals {all page bits one, addr[5:0]} whatever either page register holds.
- R4: `reg_sel_n` is low for an address in 0xF8–0xFF and high for every other address.
- R5: For any address exactly one of `rom_sel`, `ram_sel`, `sram_sel` and the inverse of `reg_sel_n` is asserted.
- R6: A write (`bus_wr`=1) to 0xFD stages the low data bits as the pending ROM page. A write to 0xFC stages the pending RAM page. Neither write alone changes `rom_page` or `ram_page`.
- R7: A write to 0xFF copies both pending pages to `rom_page` and `ram_page` at that clock edge. A pending page that was not rewritten keeps its previous value.
- R8: A write to 0xFE copies the pending pages when `carry_in` is 1 and changes nothing when `carry_in` is 0.
- R9: Synchronous reset (`rst`=1) clears the active and the pending pages to 0. A jump right after reset therefore leaves both pages at 0.
- R10: A read (`bus_rd`=1, `bus_wr`=0) of 0xFC–0xFF neither stages nor commits a page.
- R11: `sram_we` equals `bus_wr` and `sram_re` equals `bus_rd` while the address is in the static RAM region, in the same cycle with no register. Both are 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| carry_in | input | 1 | Carry flag qualifying the conditional jump |
| rom_sel | output | 1 | Paged ROM region select |
| ram_sel | output | 1 | Paged RAM region select |
| sram_sel | output | 1 | Static RAM region select |
| reg_sel_n | output | 1 | Register window select, active low |
| rom_xaddr | output | PAGE_W+7 | Extended ROM address |
| ram_xaddr | output | PAGE_W+6 | Extended RAM address |
| sram_xaddr | output | PAGE_W+6 | Extended static RAM address |
| sram_we | output | 1 | Static RAM write strobe |
| sram_re | output | 1 | Static RAM read strobe |
| rom_page | output | PAGE_W | Active ROM page |
| ram_page | output | PAGE_W | Active RAM page |

## Verification
The assertions assume one bus operation per clock. They also assume that `bus_addr`, `bus_wr` and `carry_in` are steady around the rising edge, because the commit and staging decisions sample them there. The stimulus changes every input on the falling edge only. It raises `bus_wr` at a jump or page address only when a staging or commit is intended. The region sweep that exercises the static RAM strobes keeps `bus_wr` low across the register window, so no stray jump reaches the page state.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    typedef enum logic [1:0] {
        RG_ROM  = 2'd0,
        RG_RAM  = 2'd1,
        RG_SRAM = 2'd2,
        RG_REGS = 2'd3
    } region_e;

    typedef struct packed {
        logic rom;
        logic ram;
        logic sram;
        logic regs;
    } sel_t;

    localparam int BUS_W     = 8;
    localparam int ROM_OFF_W = 7;
    localparam int RAM_OFF_W = 6;
    localparam int NUM_BANKS = 2;
    localparam int BANK_ROM  = 0;
    localparam int BANK_RAM  = 1;

    localparam logic [BUS_W-1:0] ADR_JUMP   = 8'hFF;
    localparam logic [BUS_W-1:0] ADR_JCARRY = 8'hFE;
    localparam logic [BUS_W-1:0] ADR_ROMPG  = 8'hFD;
    localparam logic [BUS_W-1:0] ADR_RAMPG  = 8'hFC;

    function automatic region_e classify(input logic [BUS_W-1:0] a);
        if (!a[7])                 return RG_ROM;
        else if (!a[6])            return RG_RAM;
        else if (a[5:3] != 3'b111) return RG_SRAM;
        else                       return RG_REGS;
    endfunction

    function automatic sel_t region_to_sel(input region_e r);
        sel_t s;
        s      = '0;
        s.rom  = (r == RG_ROM);
        s.ram  = (r == RG_RAM);
        s.sram = (r == RG_SRAM);
        s.regs = (r == RG_REGS);
        return s;
    endfunction

endpackage

// File: rtl/pgmap_region_dec.sv
module pgmap_region_dec
    import pgmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] addr,
    output sel_t             sel
);

    region_e region;

    always_comb begin
        region = classify(addr);
        sel    = region_to_sel(region);
    end

    a_r5_one_region: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);

    a_r1_rom_low_half: assert property (@(posedge clk) disable iff (rst)
        sel.rom |-> !addr[7]);

endmodule

// File: rtl/pgmap_jump_ctl.sv
module pgmap_jump_ctl
    import pgmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BUS_W-1:0]     addr,
    input  logic                 wr,
    input  logic                 carry,
    output logic                 commit,
    output logic [NUM_BANKS-1:0] stage
);

    logic hit_jump;
    logic hit_cond;

    always_comb begin
        hit_jump = wr && (addr == ADR_JUMP);
        hit_cond = wr && (addr == ADR_JCARRY) && carry;
        commit   = hit_jump || hit_cond;
        stage    = '0;
        stage[BANK_ROM] = wr && (addr == ADR_ROMPG);
        stage[BANK_RAM] = wr && (addr == ADR_RAMPG);
    end

    a_r10_no_action_on_read: assert property (@(posedge clk) disable iff (rst)
        !wr |-> (!commit && stage == '0));

    a_r6_stage_excludes_commit: assert property (@(posedge clk) disable iff (rst)
        (stage != '0) |-> !commit);

endmodule

// File: rtl/pgmap_page_bank.sv
module pgmap_page_bank #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] din,
    input  logic              commit,
    output logic [PAGE_W-1:0] active
);

    logic [PAGE_W-1:0] pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            active  <= '0;
        end else begin
            if (load)
                pending <= din;
            if (commit)
                active <= pending;
        end
    end

    a_r6_hold_without_jump: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

    a_r7_commit_copies: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active == $past(pending)));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (active == '0 && pending == '0));

endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
    import pgmap_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [7:0]                  bus_addr,
    input  logic [7:0]                  bus_wdata,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic                        carry_in,
    output logic                        rom_sel,
    output logic                        ram_sel,
    output logic                        sram_sel,
    output logic                        reg_sel_n,
    output logic [PAGE_W+ROM_OFF_W-1:0] rom_xaddr,
    output logic [PAGE_W+RAM_OFF_W-1:0] ram_xaddr,
    output logic [PAGE_W+RAM_OFF_W-1:0] sram_xaddr,
    output logic                        sram_we,
    output logic                        sram_re,
    output logic [PAGE_W-1:0]           rom_page,
    output logic [PAGE_W-1:0]           ram_page
);

    localparam logic [PAGE_W-1:0] SRAM_PAGE = '1;

    sel_t                 sel;
    logic                 commit;
    logic [NUM_BANKS-1:0] stage;
    logic [PAGE_W-1:0]    pages [NUM_BANKS];

    pgmap_region_dec u_dec (
        .clk  (clk),
        .rst  (rst),
        .addr (bus_addr),
        .sel  (sel)
    );

    pgmap_jump_ctl u_jmp (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .carry  (carry_in),
        .commit (commit),
        .stage  (stage)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pgmap_page_bank #(.PAGE_W(PAGE_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .load   (stage[b]),
            .din    (bus_wdata[PAGE_W-1:0]),
            .commit (commit),
            .active (pages[b])
        );
    end

    always_comb begin
        rom_sel    = sel.rom;
        ram_sel    = sel.ram;
        sram_sel   = sel.sram;
        reg_sel_n  = !sel.regs;
        rom_page   = pages[BANK_ROM];
        ram_page   = pages[BANK_RAM];
        rom_xaddr  = {rom_page, bus_addr[ROM_OFF_W-1:0]};
        ram_xaddr  = {ram_page, bus_addr[RAM_OFF_W-1:0]};
        sram_xaddr = {SRAM_PAGE, bus_addr[RAM_OFF_W-1:0]};
        sram_we    = bus_wr && sel.sram;
        sram_re    = bus_rd && sel.sram;
    end

    a_r8_no_carry_no_jump: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_JCARRY && !carry_in) |=>
            ($stable(rom_page) && $stable(ram_page)));

    a_r3_sram_fixed_page: assert property (@(posedge clk) disable iff (rst)
        sram_sel |-> (sram_xaddr[PAGE_W+RAM_OFF_W-1:RAM_OFF_W] == SRAM_PAGE));

    a_r11_strobe_gated: assert property (@(posedge clk) disable iff (rst)
        (sram_we || sram_re) |-> (sram_sel && reg_sel_n));

endmodule

// File: tb/pgmap_top_tb_top.sv
module pgmap_top_tb_top;

    localparam int PW = 8;
    localparam int NV = 12;
    // vector: address and expected selects {regs, sram, ram, rom}
    localparam logic [7:0] VA [NV] = '{8'h00, 8'h45, 8'h7F, 8'h80, 8'hA7, 8'hBF,
                                       8'hC0, 8'hE3, 8'hF7, 8'hF8, 8'hFC, 8'hFF};
    localparam logic [3:0] VS [NV] = '{4'b0001, 4'b0001, 4'b0001, 4'b0010, 4'b0010, 4'b0010,
                                       4'b0100, 4'b0100, 4'b0100, 4'b1000, 4'b1000, 4'b1000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic carry_in = 1'b0;
    logic rom_sel, ram_sel, sram_sel, reg_sel_n, sram_we, sram_re;
    logic [PW+6:0] rom_xaddr;
    logic [PW+5:0] ram_xaddr, sram_xaddr;
    logic [PW-1:0] rom_page, ram_page;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    pgmap_top #(.PAGE_W(PW)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .carry_in(carry_in),
        .rom_sel(rom_sel), .ram_sel(ram_sel), .sram_sel(sram_sel),
        .reg_sel_n(reg_sel_n), .rom_xaddr(rom_xaddr), .ram_xaddr(ram_xaddr),
        .sram_xaddr(sram_xaddr), .sram_we(sram_we), .sram_re(sram_re),
        .rom_page(rom_page), .ram_page(ram_page)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one bus write, all changes on the falling edge; state checked at next falling edge
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic c);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; carry_in = c; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; carry_in = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic check_pages(input string tag, input logic [7:0] er, input logic [7:0] em);
        chk({tag, " rom_page"}, 32'(rom_page), 32'(er));
        chk({tag, " ram_page"}, 32'(ram_page), 32'(em));
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_pages("R9 after reset", 8'h00, 8'h00);

        // R6: staging alone changes nothing
        bus_write(8'hFD, 8'h5A, 1'b0);
        check_pages("R6 rom stage only", 8'h00, 8'h00);
        bus_write(8'hFC, 8'h3C, 1'b0);
        check_pages("R6 ram stage only", 8'h00, 8'h00);

        // R10: reads of jump addresses do nothing
        bus_read(8'hFF);
        check_pages("R10 read of jump", 8'h00, 8'h00);
        bus_read(8'hFE);
        check_pages("R10 read of cond jump", 8'h00, 8'h00);

        // R8: conditional jump without carry
        bus_write(8'hFE, 8'h00, 1'b0);
        check_pages("R8 cond no carry", 8'h00, 8'h00);
        // R8: conditional jump with carry commits
        bus_write(8'hFE, 8'h00, 1'b1);
        check_pages("R8 cond carry", 8'h5A, 8'h3C);

        // R7: unconditional jump, only ROM restaged
        bus_write(8'hFD, 8'h11, 1'b0);
        check_pages("R6 restage", 8'h5A, 8'h3C);
        bus_write(8'hFF, 8'h00, 1'b0);
        check_pages("R7 jump", 8'h11, 8'h3C);

        // R10: read of page address does not stage
        bus_read(8'hFD);
        bus_write(8'hFF, 8'h00, 1'b0);
        check_pages("R10 read of page reg", 8'h11, 8'h3C);

        // region sweep with pages 0x11 / 0x3C
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr = VA[i];
            bus_rd = 1'b1;
            bus_wr = (VA[i] < 8'hF8);
            #2;
            chk("R5 selects", 32'({~reg_sel_n, sram_sel, ram_sel, rom_sel}), 32'(VS[i]));
            chk("R4 reg_sel_n", 32'(reg_sel_n), 32'(!VS[i][3]));
            if (VS[i][0]) chk("R1 rom_xaddr", 32'(rom_xaddr), 32'({8'h11, VA[i][6:0]}));
            if (VS[i][1]) chk("R2 ram_xaddr", 32'(ram_xaddr), 32'({8'h3C, VA[i][5:0]}));
            if (VS[i][2]) chk("R3 sram_xaddr", 32'(sram_xaddr), 32'({8'hFF, VA[i][5:0]}));
            chk("R11 sram_re", 32'(sram_re), 32'(VS[i][2]));
            chk("R11 sram_we", 32'(sram_we), 32'(VS[i][2]));
            bus_wr = 1'b0; bus_rd = 1'b0;
        end
        @(negedge clk);
        bus_addr = 8'hD0; bus_wr = 1'b0; bus_rd = 1'b0;
        #2;
        chk("R11 sram idle we", 32'(sram_we), 32'h0);
        chk("R11 sram idle re", 32'(sram_re), 32'h0);
        check_pages("R5 sweep left pages", 8'h11, 8'h3C);

        // R9: reset clears pending as well
        bus_write(8'hFD, 8'h77, 1'b0);
        bus_write(8'hFC, 8'h66, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_pages("R9 reset active", 8'h00, 8'h00);
        bus_write(8'hFF, 8'h00, 1'b0);
        check_pages("R9 pending cleared", 8'h00, 8'h00);

        // R3: static RAM page fixed with non-zero pages
        bus_write(8'hFD, 8'h02, 1'b0);
        bus_write(8'hFC, 8'h81, 1'b0);
        bus_write(8'hFF, 8'h00, 1'b0);
        check_pages("R7 second jump", 8'h02, 8'h81);
        @(negedge clk); bus_addr = 8'hF7; #2;
        chk("R3 sram top", 32'(sram_xaddr), 32'({8'hFF, 6'h37}));
        bus_addr = 8'h7F; #2;
        chk("R1 rom top", 32'(rom_xaddr), 32'({8'h02, 7'h7F}));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule